// File: doc/BRIEF.md
# Configurable CRC-16 / CRC-32 Checksum Engine

This block computes a running checksum over a stream of data beats. A small register port holds a configuration word, a command word and a data word. The configuration word picks where the data comes from, which polynomial is used and how wide each beat is. Data comes from one of two places. Software can write beats into the data word. Alternatively, one of several DMA request streams can feed the block; each stream is tagged with a channel index, and the block takes only beats from the chosen channel.

The command word turns the engine on and off and lets software close a calculation. A calculation starts with the first accepted beat, and a busy flag is raised at that point. It ends in one of three ways: a completion command in software mode, the completion pulse of the selected DMA channel, or disabling the engine. The configuration, including the source selection, can only be written while the engine is disabled, so the source stays fixed for the whole of a calculation. Disabling the engine clears busy and reloads the seed of the selected polynomial.

Top module: `crc_engine`

## Requirements
- R1: After reset the configuration reads as 0x0000, the engine is disabled, busy and the error flag are low, and `crc_out` is 0x0000FFFF.
- R2: A write to address 0 loads the configuration: source select in bits 13:8, polynomial in bits 3:2, beat size in bits 1:0. All other bits read back as zero. The write is accepted only while the engine is disabled, and it reloads the seed of the new polynomial.
- R3: A write to address 1 sets the enable bit from bit 0. Writing bit 0 as 0 disables the engine, clears busy and reloads the seed, so `crc_out` reads 0x0000FFFF for CRC-16 and 0x00000000 for CRC-32.
- R4: Source code 0x01 takes beats from writes to address 2. Codes 0x20 to 0x2B take beats from DMA channel 0 to 11, the channel index being the low four bits. With any other code, or while disabled, beats are ignored and the checksum does not change.
- R5: Polynomial code 0 is CRC-16: polynomial 0x1021, seed 0xFFFF, bits taken most significant first, no reflection and no final XOR. The result sits in `crc_out[15:0]` with the upper half zero, so the ASCII bytes "123456789" give 0x29B1.
- R6: Polynomial code 1 is CRC-32: polynomial 0x04C11DB7, seed 0xFFFFFFFF, reflected input and output, and a final XOR of 0xFFFFFFFF. The ASCII bytes "123456789" give 0xCBF43926.
- R7: Beat size code 0, 1 or 2 folds 1, 2 or 4 bytes of the beat data per beat. The least significant byte is folded first.
- R8: The first accepted beat of a calculation raises busy and folds from the seed. A beat accepted while busy is low (after a completion) starts a fresh calculation from the seed.
- R9: In software mode, a write to address 1 with bit 1 set clears busy. The result stays on `crc_out`.
- R10: In DMA mode, `dma_done` with `dma_done_chan` equal to the selected channel clears busy. Completion pulses and beats from other channels are ignored.
- R11: A beat that arrives while a reserved polynomial (2, 3) or beat size (3) is selected leaves the checksum and busy unchanged and sets `cfg_err`. A configuration write clears `cfg_err`.
- R12: While busy is high, the engine is enabled, so a write to the source select is ignored until the calculation completes or the engine is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 configuration, 1 command, 2 data |
| reg_wdata | input | 32 | Register write data |
| dma_valid | input | 1 | DMA beat valid |
| dma_chan | input | 4 | Channel index of the DMA beat |
| dma_data | input | 32 | DMA beat data |
| dma_done | input | 1 | DMA completion pulse |
| dma_done_chan | input | 4 | Channel index of the completion pulse |
| ctrl_q | output | 16 | Configuration read-back |
| enabled | output | 1 | Enable state |
| busy | output | 1 | Calculation in progress, source locked |
| cfg_err | output | 1 | Beat seen with a reserved configuration |
| crc_out | output | 32 | Current checksum, finalised for the selected polynomial |

## Verification
The bench checks both polynomials against the standard nine-byte check value. These tests catch a reflection or a final XOR that is missing or wrong, as well as reversed bit order within a byte. Every beat width is compared against an independent byte-wise model; a design that folds the bytes most significant first, or folds the wrong number of bytes, gives a different checksum. The bench tries to change the configuration while busy, sends beats and completion pulses on channels that are not selected, and sends beats while a reserved code is selected. A design with a leaky lock would switch source in the middle of a calculation, and a design with a loose channel match would fold foreign data. It also checks that a beat arriving after completion restarts from the seed. A design that missed this would keep accumulating into the old result.

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int CH_COUNT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        dma_valid,
  input  logic [3:0]  dma_chan,
  input  logic [31:0] dma_data,
  input  logic        dma_done,
  input  logic [3:0]  dma_done_chan,
  output logic [15:0] ctrl_q,
  output logic        enabled,
  output logic        busy,
  output logic        cfg_err,
  output logic [31:0] crc_out
);
  localparam logic [31:0] POLY32 = 32'h04C11DB7;
  localparam logic [15:0] POLY16 = 16'h1021;
  localparam logic [5:0]  SRC_IO = 6'h01;

  logic [5:0]  src;
  logic [1:0]  poly, beat;
  logic        en, busy_q, err_q;
  logic [31:0] st;

  function automatic logic [31:0] seed_of(input logic [1:0] p);
    return (p == 2'd1) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] fold(input logic [31:0] s_in, input logic [31:0] d,
                                       input logic [1:0] bs, input logic p32);
    logic [31:0] s;
    logic b, fb;
    int nb;
    s = s_in;
    nb = (bs == 2'd0) ? 1 : (bs == 2'd1) ? 2 : 4;
    for (int k = 0; k < 32; k++) begin
      if ((k / 8) < nb) begin
        b = p32 ? d[k] : d[(k / 8) * 8 + 7 - (k % 8)];
        if (p32) begin
          fb = s[31] ^ b;
          s  = {s[30:0], 1'b0} ^ (fb ? POLY32 : 32'h0);
        end else begin
          fb = s[15] ^ b;
          s  = {16'h0, s[14:0], 1'b0} ^ (fb ? {16'h0, POLY16} : 32'h0);
        end
      end
    end
    return s;
  endfunction

  wire wr_ctrl  = reg_wr && (reg_addr == 2'd0);
  wire wr_cmd   = reg_wr && (reg_addr == 2'd1);
  wire wr_data  = reg_wr && (reg_addr == 2'd2);
  wire src_io   = (src == SRC_IO);
  wire src_dma  = (src[5:4] == 2'b10) && (int'(src[3:0]) < CH_COUNT);
  wire dma_hit  = dma_valid && (dma_chan == src[3:0]);
  wire beat_in  = en && ((src_io && wr_data) || (src_dma && dma_hit));
  wire cfg_ok   = (poly < 2'd2) && (beat < 2'd3);
  wire fold_ok  = beat_in && cfg_ok;
  wire dis      = wr_cmd && !reg_wdata[0];
  wire fin      = busy_q && ((src_io && wr_cmd && reg_wdata[1]) ||
                             (src_dma && dma_done && (dma_done_chan == src[3:0])));
  wire [31:0] beat_data = src_io ? reg_wdata : dma_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src    <= '0;
      poly   <= '0;
      beat   <= '0;
      en     <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      st     <= 32'h0000_FFFF;
    end else begin
      if (wr_ctrl && !en) begin
        src   <= reg_wdata[13:8];
        poly  <= reg_wdata[3:2];
        beat  <= reg_wdata[1:0];
        st    <= seed_of(reg_wdata[3:2]);
        err_q <= 1'b0;
      end
      if (wr_cmd) en <= reg_wdata[0];
      if (dis) begin
        busy_q <= 1'b0;
        st     <= seed_of(poly);
      end else begin
        if (beat_in && !cfg_ok) err_q <= 1'b1;
        if (fold_ok) begin
          st     <= fold(busy_q ? st : seed_of(poly), beat_data, beat, poly[0]);
          busy_q <= 1'b1;
        end
        if (fin) busy_q <= 1'b0;
      end
    end
  end

  logic [31:0] st_rev;
  always_comb begin
    for (int i = 0; i < 32; i++) st_rev[i] = st[31 - i];
  end

  assign crc_out = (poly == 2'd1) ? ~st_rev : {16'h0, st[15:0]};
  assign ctrl_q  = {2'b00, src, 4'b0000, poly, beat};
  assign enabled = en;
  assign busy    = busy_q;
  assign cfg_err = err_q;

  p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && en) |=> $stable(ctrl_q));

  p_disable_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (!busy_q && st == ((poly == 2'd1) ? 32'hFFFF_FFFF : 32'h0000_FFFF)));

  p_ignore_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !beat_in && !dis) |=> $stable(st));

  p_first_beat_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_ok && !dis && !fin) |=> busy_q);

  p_reserved_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_in && !cfg_ok && !dis) |=> ($stable(st) && err_q));

  p_busy_in_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> en);
endmodule

// File: tb/test_crc_engine.sv
module test_crc_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        dma_valid = 1'b0;
  logic [3:0]  dma_chan = '0;
  logic [31:0] dma_data = '0;
  logic        dma_done = 1'b0;
  logic [3:0]  dma_done_chan = '0;
  logic [15:0] ctrl_q;
  logic        enabled, busy, cfg_err;
  logic [31:0] crc_out;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;
  logic [31:0] mst;

  always #(CLK_PERIOD / 2) clk = ~clk;

  crc_engine i_crc_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dma_valid(dma_valid), .dma_chan(dma_chan), .dma_data(dma_data),
    .dma_done(dma_done), .dma_done_chan(dma_done_chan),
    .ctrl_q(ctrl_q), .enabled(enabled), .busy(busy), .cfg_err(cfg_err), .crc_out(crc_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] b, input bit p32);
    logic [31:0] r;
    r = c;
    if (p32) begin
      r = r ^ {24'h0, b};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end else begin
      r[15:0] = r[15:0] ^ {b, 8'h00};
      for (int i = 0; i < 8; i++)
        r[15:0] = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
      r[31:16] = 16'h0;
    end
    return r;
  endfunction

  function automatic logic [31:0] m_beat(input logic [31:0] c, input logic [31:0] d,
                                         input int nbytes, input bit p32);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < nbytes; i++) r = m_byte(r, d[8*i +: 8], p32);
    return r;
  endfunction

  function automatic logic [31:0] m_out(input logic [31:0] c, input bit p32);
    return p32 ? ~c : {16'h0, c[15:0]};
  endfunction

  function automatic logic [31:0] m_seed(input bit p32);
    return p32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cfg(input logic [5:0] s, input logic [1:0] p, input logic [1:0] b);
    wr(2'd0, {16'h0, 2'b00, s, 4'h0, p, b});
  endtask

  task automatic dma_beat(input logic [3:0] ch, input logic [31:0] d);
    @(negedge clk);
    dma_valid = 1'b1; dma_chan = ch; dma_data = d;
    @(negedge clk);
    dma_valid = 1'b0;
  endtask

  task automatic dma_fin(input logic [3:0] ch);
    @(negedge clk);
    dma_done = 1'b1; dma_done_chan = ch;
    @(negedge clk);
    dma_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", {16'h0, ctrl_q}, 32'h0);
    chk("R1 enabled", {31'h0, enabled}, 32'h0);
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 err", {31'h0, cfg_err}, 32'h0);
    chk("R1 crc", crc_out, 32'h0000_FFFF);
  endtask

  task automatic t_check_string(input bit p32, input logic [31:0] expv);
    wr(2'd1, 32'h0);
    cfg(6'h01, p32 ? 2'd1 : 2'd0, 2'd0);
    wr(2'd1, 32'h1);
    chk("R8 idle before beat", {31'h0, busy}, 32'h0);
    for (int i = 0; i < 9; i++) begin
      wr(2'd2, 32'h31 + i);
      if (i == 0) chk("R8 busy on first beat", {31'h0, busy}, 32'h1);
    end
    chk(p32 ? "R6 crc32 check value" : "R5 crc16 check value", crc_out, expv);
    wr(2'd1, 32'h3);
    chk("R9 busy cleared by completion", {31'h0, busy}, 32'h0);
    chk("R9 result held", crc_out, expv);
  endtask

  task automatic t_widths;
    logic [31:0] words [3];
    words[0] = 32'hDEADBEEF; words[1] = 32'h01234567; words[2] = 32'hA5C30F96;
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 3; b++) begin
        wr(2'd1, 32'h0);
        cfg(6'h01, 2'(p), 2'(b));
        wr(2'd1, 32'h1);
        mst = m_seed(p == 1);
        for (int w = 0; w < 3; w++) begin
          wr(2'd2, words[w]);
          mst = m_beat(mst, words[w], 1 << b, p == 1);
        end
        chk("R7 beat width fold", crc_out, m_out(mst, p == 1));
        wr(2'd1, 32'h3);
        wr(2'd2, 32'h5A5A5A5A);
        mst = m_beat(m_seed(p == 1), 32'h5A5A5A5A, 1 << b, p == 1);
        chk("R8 restart from seed after completion", crc_out, m_out(mst, p == 1));
        wr(2'd1, 32'h3);
      end
    end
  endtask

  task automatic t_lock;
    logic [31:0] held;
    wr(2'd1, 32'h0);
    cfg(6'h01, 2'd0, 2'd0);
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h41);
    cfg(6'h21, 2'd1, 2'd2);
    chk("R12 source locked while busy", {16'h0, ctrl_q}, 32'h0000_0100);
    chk("R12 busy kept", {31'h0, busy}, 32'h1);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R2 field layout, spare bits zero", {16'h0, ctrl_q}, 32'h0000_3F0F);
    cfg(6'h05, 2'd0, 2'd0);
    wr(2'd1, 32'h1);
    held = crc_out;
    wr(2'd2, 32'h12);
    chk("R4 reserved source ignores data", crc_out, held);
    chk("R4 reserved source no busy", {31'h0, busy}, 32'h0);
    wr(2'd1, 32'h0);
    cfg(6'h00, 2'd1, 2'd0);
    wr(2'd1, 32'h1);
    held = crc_out;
    wr(2'd2, 32'h12);
    dma_beat(4'd0, 32'h34);
    chk("R4 no-action source ignores data", crc_out, held);
  endtask

  task automatic t_dma;
    logic [31:0] held;
    wr(2'd1, 32'h0);
    cfg(6'h25, 2'd1, 2'd2);
    wr(2'd1, 32'h1);
    mst = m_seed(1'b1);
    dma_beat(4'd5, 32'hCAFEF00D);
    mst = m_beat(mst, 32'hCAFEF00D, 4, 1'b1);
    dma_beat(4'd3, 32'h11111111);
    wr(2'd2, 32'h22222222);
    dma_beat(4'd5, 32'h0BADC0DE);
    mst = m_beat(mst, 32'h0BADC0DE, 4, 1'b1);
    chk("R10 only selected channel folded", crc_out, m_out(mst, 1'b1));
    dma_fin(4'd2);
    chk("R10 foreign completion ignored", {31'h0, busy}, 32'h1);
    dma_fin(4'd5);
    chk("R10 completion clears busy", {31'h0, busy}, 32'h0);
    chk("R10 result held", crc_out, m_out(mst, 1'b1));
    wr(2'd1, 32'h0);
    cfg(6'h2C, 2'd0, 2'd0);
    wr(2'd1, 32'h1);
    held = crc_out;
    dma_beat(4'd12, 32'h77);
    chk("R4 channel code past range ignored", crc_out, held);
  endtask

  task automatic t_reserved;
    wr(2'd1, 32'h0);
    cfg(6'h01, 2'd2, 2'd0);
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h55);
    chk("R11 reserved poly keeps crc", crc_out, 32'h0000_FFFF);
    chk("R11 reserved poly sets err", {31'h0, cfg_err}, 32'h1);
    chk("R11 reserved poly no busy", {31'h0, busy}, 32'h0);
    wr(2'd1, 32'h0);
    cfg(6'h01, 2'd0, 2'd3);
    chk("R11 config write clears err", {31'h0, cfg_err}, 32'h0);
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h55);
    chk("R11 reserved beat keeps crc", crc_out, 32'h0000_FFFF);
    chk("R11 reserved beat sets err", {31'h0, cfg_err}, 32'h1);
  endtask

  task automatic t_disable;
    wr(2'd1, 32'h0);
    cfg(6'h01, 2'd1, 2'd0);
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h99);
    chk("R3 busy before disable", {31'h0, busy}, 32'h1);
    wr(2'd1, 32'h0);
    chk("R3 disable clears busy", {31'h0, busy}, 32'h0);
    chk("R3 disable reloads crc32 seed", crc_out, 32'h0);
    chk("R3 enabled low", {31'h0, enabled}, 32'h0);
    cfg(6'h01, 2'd0, 2'd1);
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h1234);
    wr(2'd1, 32'h0);
    chk("R3 disable reloads crc16 seed", crc_out, 32'h0000_FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_check_string(1'b0, 32'h0000_29B1);
    t_check_string(1'b1, 32'hCBF4_3926);
    t_widths();
    t_lock();
    t_dma();
    t_reserved();
    t_disable();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule